// File: doc/BRIEF.md
# Multiplexed-Bus Counter Readout Port

This block lets a host processor read one of several 8-bit position counts over a shared 8-bit address/data bus. In the address phase, the host places a channel number on the bus and pulses the address-latch strobe. The block remembers that channel. In the data phase, the host pulls the active-low read strobe down. The block then drives a frozen copy of the chosen channel's count onto the bus. While the read strobe is high, the block leaves the bus floating. This means the host, or any other device, is free to drive it.

The strobes are sampled on the system clock. The host is expected to hold each strobe level for at least one clock period. The count inputs come from counters elsewhere in the chip and can change on any cycle. The value seen on the bus stays fixed for the whole of one read.

The reset input clears the block at once. Its release passes through a two-stage synchroniser, so the block leaves reset on the second rising clock edge after the reset input goes high.

Top module: `cnt_bus_readout`

## Requirements
- R1: Four channels are selectable. The channel number is taken from bus bits [1:0] only, and bits [7:2] have no effect on which channel is read.
- R2: At the first clock edge where the latch strobe is sampled low after being sampled high, the channel number is loaded from the bus value sampled at the previous edge. This is the last cycle the strobe was high. The channel then holds until the next strobe pulse, whatever the bus carries meanwhile.
- R3: At the first clock edge where the read strobe is sampled low, the block snapshots the count of the latched channel. It starts driving that value on the bus from that edge.
- R4: While the read strobe stays low, the driven value does not change, even if the selected count changes. A later read returns the updated count.
- R5: At the first clock edge where the read strobe is sampled high, the block releases the bus to high impedance. It drives nothing while the strobe remains high.
- R6: The write strobe has no effect. It changes neither the channel, nor the value driven, nor when the bus is driven.
- R7: While reset is held, the bus is released and the channel number is 0. Reset release takes effect at the second rising edge after the reset input rises. Until then, a low read strobe does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address-latch strobe, active high |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, ignored |
| ad_io | inout | 8 | Shared address/data bus |
| cnt_i | input | 32 | Four packed counts, channel k at bits [8k+7:8k] |

## Verification
The in-RTL properties check the following on every cycle:
- the channel register never moves while the latch strobe is high;
- a freshly started read carries the count that was selected one cycle earlier;
- the driven value stays frozen for as long as the read lasts, including while the write strobe is low;
- the bus is released after any cycle in which the read strobe was high;
- the bus is idle during reset.

Only the bench scenarios can show the following:
- that the upper bus bits are really ignored during the address phase;
- that the last value before the strobe falls is the one kept;
- that a count change lands on the next read and not the current one;
- that the bus is truly floating, which is shown by driving two complementary patterns onto it and reading each back intact;
- the two-edge delay on reset release.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

  localparam int unsigned CMR_NCH_DEF    = 4;
  localparam int unsigned CMR_DW_DEF     = 8;
  localparam int unsigned CMR_RST_STAGES = 2;

  typedef enum logic {
    BUS_RELEASED = 1'b0,
    BUS_DRIVEN   = 1'b1
  } bus_state_e;

endpackage

// File: rtl/cmr_rst_sync.sv
module cmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign pipe_d = {pipe_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      assign pipe_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_no = pipe_q[STAGES-1];

endmodule

// File: rtl/cmr_addr_latch.sv
module cmr_addr_latch #(
  parameter int unsigned SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic [SW-1:0] adr_i,
  output logic [SW-1:0] sel_o
);

  logic          ale_q;
  logic [SW-1:0] adr_q, adr_d;
  logic [SW-1:0] sel_q, sel_d;
  logic          ale_fall;
  logic          adr_en;

  // next state
  always_comb begin
    ale_fall = ale_q & ~ale_i;
    adr_en   = ale_i;
    adr_d    = adr_en   ? adr_i : adr_q;
    sel_d    = ale_fall ? adr_q : sel_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q <= 1'b0;
      adr_q <= '0;
      sel_q <= '0;
    end else begin
      ale_q <= ale_i;
      adr_q <= adr_d;
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ale_i) |-> $stable(sel_q));

endmodule

// File: rtl/cmr_read_port.sv
module cmr_read_port
  import cmr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8,
  parameter int unsigned SW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [SW-1:0]     sel_i,
  input  logic [NCH*DW-1:0] cnt_i,
  output logic [DW-1:0]     dat_o,
  output logic              drv_o
);

  logic [DW-1:0] lane [NCH];

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_lane
      assign lane[k] = cnt_i[k*DW +: DW];
    end
  endgenerate

  bus_state_e    st_q, st_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [DW-1:0] cnt_sel;
  logic          snap_en;

  // next state
  always_comb begin
    cnt_sel = lane[sel_i];
    st_d    = rd_ni ? BUS_RELEASED : BUS_DRIVEN;
    snap_en = (st_q == BUS_RELEASED) && !rd_ni;
    dat_d   = snap_en ? cnt_sel : dat_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BUS_RELEASED;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      dat_q <= dat_d;
    end
  end

  assign dat_o = dat_q;
  assign drv_o = (st_q == BUS_DRIVEN);

  // R3
  snap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_o && !$past(drv_o)) |-> (dat_o == $past(cnt_sel)));

  // R4
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_o && $past(drv_o)) |-> $stable(dat_o));

  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_ni) |-> !drv_o);

  // R6
  wr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && drv_o && $past(drv_o)) |-> $stable(dat_o));

  // R7
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !drv_o);

endmodule

// File: rtl/cnt_bus_readout.sv
module cnt_bus_readout
  import cmr_pkg::*;
#(
  parameter int unsigned NCH = CMR_NCH_DEF,
  parameter int unsigned DW  = CMR_DW_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  inout  wire  [DW-1:0]     ad_io,
  input  logic [NCH*DW-1:0] cnt_i
);

  localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          rst_sync_n;
  logic [SW-1:0] sel;
  logic [DW-1:0] dat;
  logic          drv;

  cmr_rst_sync #(.STAGES(CMR_RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cmr_addr_latch #(.SW(SW)) u_adr (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .ale_i  (ale_i),
    .adr_i  (ad_io[SW-1:0]),
    .sel_o  (sel)
  );

  cmr_read_port #(.NCH(NCH), .DW(DW), .SW(SW)) u_rdp (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .rd_ni  (rd_ni),
    .wr_ni  (wr_ni),
    .sel_i  (sel),
    .cnt_i  (cnt_i),
    .dat_o  (dat),
    .drv_o  (drv)
  );

  assign ad_io = drv ? dat : {DW{1'bz}};

endmodule

// File: tb/sim_cnt_bus_readout.sv
module sim_cnt_bus_readout;

  logic       clk = 1'b0;
  logic       rst_n, ale, rd_n, wr_n;
  logic       host_drv;
  logic [7:0] host_val;
  logic [7:0] cv [4];
  wire  [7:0] ad_bus;
  wire [31:0] cnt_flat = {cv[3], cv[2], cv[1], cv[0]};

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  assign ad_bus = host_drv ? host_val : 8'bz;

  cnt_bus_readout u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .ale_i  (ale),
    .rd_ni  (rd_n),
    .wr_ni  (wr_n),
    .ad_io  (ad_bus),
    .cnt_i  (cnt_flat)
  );

  // address bytes: channel in bits [1:0], junk above
  localparam logic [7:0] ADDR_VEC [8] = '{8'h00, 8'hFD, 8'h02, 8'h83,
                                          8'h7C, 8'h41, 8'hE2, 8'h0B};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // floating bus reads back both complementary patterns intact
  task automatic chk_float(input string req);
    host_drv = 1'b1;
    host_val = 8'hA5; #1;
    chk(req, ad_bus, 8'hA5);
    host_val = 8'h5A; #1;
    chk(req, ad_bus, 8'h5A);
    host_drv = 1'b0;
  endtask

  task automatic set_chan(input logic [7:0] a);
    host_drv = 1'b1; host_val = a; ale = 1'b1;
    tick();
    ale = 1'b0;
    tick();
    host_drv = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    rd_n = 1'b0;
    tick();
    chk(req, ad_bus, exp);
    rd_n = 1'b1;
    tick();
    chk_float("R5");
  endtask

  initial begin
    rst_n = 1'b0; ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    host_drv = 1'b0; host_val = 8'h00;
    cv[0] = 8'h1A; cv[1] = 8'h2B; cv[2] = 8'h3C; cv[3] = 8'h4D;

    // R7: reset holds bus released even with read low, latch pulse ignored
    tick();
    rd_n = 1'b0; host_drv = 1'b1; host_val = 8'h03; ale = 1'b1;
    tick(); tick();
    ale = 1'b0; host_drv = 1'b0;
    tick();
    chk_float("R7");

    // R7: synchronized release, read stays low
    rst_n = 1'b1;
    tick();
    chk_float("R7");
    tick();
    chk_float("R7");
    tick();
    chk("R7", ad_bus, cv[0]);
    rd_n = 1'b1;
    tick();
    chk_float("R5");

    // R1: table walk, upper address bits are junk
    for (int i = 0; i < 8; i++) begin
      set_chan(ADDR_VEC[i]);
      do_read(cv[ADDR_VEC[i][1:0]], "R1");
    end

    // R2: last value before the strobe falls wins; later bus traffic ignored
    host_drv = 1'b1; host_val = 8'h01; ale = 1'b1;
    tick();
    host_val = 8'h03;
    tick();
    ale = 1'b0;
    tick();
    host_val = 8'h02;
    tick(); tick();
    host_drv = 1'b0;
    do_read(cv[3], "R2");
    do_read(cv[3], "R2");

    // R3, R4: snapshot frozen during read, next read updated
    set_chan(8'h02);
    rd_n = 1'b0;
    tick();
    chk("R3", ad_bus, 8'h3C);
    cv[2] = 8'h99;
    tick(); tick();
    chk("R4", ad_bus, 8'h3C);
    rd_n = 1'b1;
    tick();
    chk_float("R5");
    do_read(8'h99, "R4");

    // R6: write strobe during read, during latch, and on its own
    rd_n = 1'b0;
    tick();
    wr_n = 1'b0;
    cv[2] = 8'h77;
    tick();
    chk("R6", ad_bus, 8'h99);
    rd_n = 1'b1;
    tick();
    chk_float("R6");
    tick();
    chk_float("R6");
    set_chan(8'h01);
    wr_n = 1'b1;
    do_read(cv[1], "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule